// File: doc/BRIEF.md
# Command-Driven Interval Timer Channel

This block is one 32-bit interval timer channel, controlled through a small window of word-aligned registers. Software starts, stops and clears the channel by writing to dedicated command offsets. The data written to those offsets has no effect, so a single store is enough to issue a command. The channel counts upward on cycles where an external one-cycle tick strobe is high and the channel is enabled. When the count reaches the programmed terminal value, the channel raises a sticky pending flag and goes back to zero.

In continuous mode the channel keeps running and raises a new event every period. In one-shot mode it stops after the first event and drops back to idle. The interrupt line is a level output. It is high while an event is pending and interrupts are enabled. A packed status word reports the run state, mode and interrupt flags in a single read.

The register port is synchronous: one write per cycle through an address, a write strobe and write data. Read data is combinational from the address. Reset is synchronous and active high.

Top module: `evtimer_chan`

## Requirements
- R1: After reset the status word reads 0x01 (idle, disabled, continuous, interrupt disabled, nothing pending), the current count reads 0, the terminal count reads 0xFFFFFFFF and `irq` is low.
- R2: The status word (offset 0x10) carries a state code in bits [3:0] (1 = idle, 2 = active, active exactly while enabled), enable in bit 4, mode in bit 5 (1 = one-shot), interrupt-enable in bit 6 and pending in bit 7; higher bits read 0.
- R3: A write to offset 0x04 enables the channel and a write to offset 0x08 disables it, whatever the write data.
- R4: The count (offset 0x14) advances by one only on a clock edge where `tick_en` is high and the channel is enabled; otherwise it holds.
- R5: On an advancing edge where the count is at or above the terminal count (offset 0x18), the count returns to 0 and pending is set; in continuous mode the channel stays enabled and repeats every terminal-count-plus-one ticks.
- R6: In one-shot mode (mode register offset 0x0C, bit 0 = 1; bit 0 = 0 is continuous), the first expiry also clears the enable, so the state code returns to idle and further ticks leave the count at 0.
- R7: Pending is sticky. A write to offset 0x20 with bit 7 set clears it. A write there with bit 7 clear leaves it unchanged. An expiry on the same edge as a clearing write wins.
- R8: `irq` is high exactly when pending and interrupt-enable are both set; interrupt-enable is bit 0 of offset 0x1C.
- R9: The terminal count reads back the last value written, and the mode and interrupt-enable bits take bit 0 of their write data.
- R10: A write of any value to offset 0x00 clears the count and pending, disables the channel and keeps the mode, interrupt-enable and terminal count.
- R11: With a terminal count of 0xFFFFFFFF the channel runs as a free counter that raises no event before the full 32-bit range wraps.
- R12: Reads of any offset other than 0x10, 0x14 and 0x18 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle count strobe |
| reg_addr | input | 6 | Byte offset within the channel window |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt, pending and enabled |

## Verification
A wrong enable bit shows up in the status state code on the very next read. A wrong count shows up in the count register, and then as an event that arrives too early or too late, one terminal-count period after the error. A lost or stuck pending flag is seen on `irq` and status bit 7 right after the clock edge that should have changed it, for example an expiry, a clearing acknowledge, or a reset command that carries random data. The stimulus keeps terminal counts small, so every fault propagates to an expiry within a few ticks, and the ports are compared against a reference model after every operation.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int unsigned CNT_W  = 32;
    localparam int unsigned ADDR_W = 6;
    localparam int unsigned STAT_W = 8;

    // Offsets inside the channel window
    localparam logic [ADDR_W-1:0] OFF_CLEAR  = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_START  = 6'h04;
    localparam logic [ADDR_W-1:0] OFF_STOP   = 6'h08;
    localparam logic [ADDR_W-1:0] OFF_MODE   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 6'h10;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFF_LIMIT  = 6'h18;
    localparam logic [ADDR_W-1:0] OFF_IRQEN  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFF_ACK    = 6'h20;

    localparam int unsigned ACK_BIT = 7;

    typedef enum logic [3:0] {
        RUN_IDLE   = 4'd1,
        RUN_ACTIVE = 4'd2
    } run_state_e;

    // Decoded one-hot write commands for a cycle
    typedef struct packed {
        logic clear;
        logic start;
        logic stop;
        logic mode_wr;
        logic limit_wr;
        logic irqen_wr;
        logic ack;
    } evt_cmd_t;

    typedef struct packed {
        logic en;
        logic oneshot;
        logic irqen;
    } evt_ctrl_t;

    typedef struct packed {
        logic       pending;
        logic       irqen;
        logic       oneshot;
        logic       en;
        run_state_e state;
    } evt_status_t;

    function automatic evt_status_t pack_status(evt_ctrl_t c, logic pend);
        evt_status_t s;
        s.pending = pend;
        s.irqen   = c.irqen;
        s.oneshot = c.oneshot;
        s.en      = c.en;
        s.state   = c.en ? RUN_ACTIVE : RUN_IDLE;
        return s;
    endfunction

endpackage

// File: rtl/evt_regdec.sv
module evt_regdec
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output evt_cmd_t          cmd
);

    always_comb begin
        cmd = '0;
        if (wr) begin
            unique case (addr)
                OFF_CLEAR: cmd.clear    = 1'b1;
                OFF_START: cmd.start    = 1'b1;
                OFF_STOP:  cmd.stop     = 1'b1;
                OFF_MODE:  cmd.mode_wr  = 1'b1;
                OFF_LIMIT: cmd.limit_wr = 1'b1;
                OFF_IRQEN: cmd.irqen_wr = 1'b1;
                OFF_ACK:   cmd.ack      = 1'b1;
                default:   cmd          = '0;
            endcase
        end
    end

    // At most one command per write
    a_r3_onehot_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd));

    a_r3_idle_no_cmd: assert property (@(posedge clk) disable iff (rst)
        !wr |-> (cmd == '0));

endmodule

// File: rtl/evt_core.sv
module evt_core
    import evt_pkg::*;
#(
    parameter int unsigned      W        = CNT_W,
    parameter logic [W-1:0]     LIMIT_RST = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  evt_cmd_t     cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic [W-1:0] limit,
    output evt_ctrl_t    ctrl,
    output logic         pending
);

    logic advance;
    logic expire;

    // A clear or stop command in the same cycle suppresses counting
    assign advance = ctrl.en && tick_en && !cmd.clear && !cmd.stop;
    assign expire  = advance && (count >= limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= '0;
            limit   <= LIMIT_RST;
            ctrl    <= '0;
            pending <= 1'b0;
        end else begin
            if (cmd.clear)
                count <= '0;
            else if (expire)
                count <= '0;
            else if (advance)
                count <= count + W'(1);

            if (cmd.limit_wr)
                limit <= wdata;

            if (cmd.clear || cmd.stop)
                ctrl.en <= 1'b0;
            else if (cmd.start)
                ctrl.en <= 1'b1;
            else if (expire && ctrl.oneshot)
                ctrl.en <= 1'b0;

            if (cmd.mode_wr)
                ctrl.oneshot <= wdata[0];
            if (cmd.irqen_wr)
                ctrl.irqen <= wdata[0];

            if (cmd.clear)
                pending <= 1'b0;
            else if (expire)
                pending <= 1'b1;
            else if (cmd.ack && wdata[ACK_BIT])
                pending <= 1'b0;
        end
    end

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !cmd.clear) |=> $stable(count));

    a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && ctrl.oneshot && tick_en && (count >= limit) && !cmd.start)
        |=> !ctrl.en);

    a_r7_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        (pending && !cmd.clear && !cmd.ack) |=> pending);

    a_r3_start_enables: assert property (@(posedge clk) disable iff (rst)
        cmd.start |=> ctrl.en);

    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        cmd.clear |=> (count == '0) && !pending && !ctrl.en);

endmodule

// File: rtl/evt_readmux.sv
module evt_readmux
    import evt_pkg::*;
#(
    parameter int unsigned W = CNT_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      count,
    input  logic [W-1:0]      limit,
    input  evt_status_t       status,
    output logic [W-1:0]      rdata
);

    always_comb begin
        unique case (addr)
            OFF_STATUS: rdata = W'(status);
            OFF_COUNT:  rdata = count;
            OFF_LIMIT:  rdata = limit;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/evtimer_chan.sv
module evtimer_chan
    import evt_pkg::*;
#(
    parameter int unsigned       W         = CNT_W,
    parameter logic [W-1:0]      LIMIT_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [W-1:0]      reg_wdata,
    output logic [W-1:0]      reg_rdata,
    output logic              irq
);

    evt_cmd_t    cmd;
    evt_ctrl_t   ctrl;
    evt_status_t status;
    logic [W-1:0] count;
    logic [W-1:0] limit;
    logic         pending;

    evt_regdec u_dec (
        .clk  (clk),
        .rst  (rst),
        .wr   (reg_wr),
        .addr (reg_addr),
        .cmd  (cmd)
    );

    evt_core #(.W(W), .LIMIT_RST(LIMIT_RST)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .cmd     (cmd),
        .wdata   (reg_wdata),
        .count   (count),
        .limit   (limit),
        .ctrl    (ctrl),
        .pending (pending)
    );

    assign status = pack_status(ctrl, pending);

    evt_readmux #(.W(W)) u_rd (
        .addr   (reg_addr),
        .count  (count),
        .limit  (limit),
        .status (status),
        .rdata  (reg_rdata)
    );

    assign irq = status.pending & status.irqen;

    a_r8_irq_needs_both: assert property (@(posedge clk) disable iff (rst)
        irq |-> (pending && ctrl.irqen));

    a_r2_state_tracks_en: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |-> (status.state == RUN_ACTIVE));

endmodule

// File: tb/evtimer_chan_tb.sv
module evtimer_chan_tb;
    import evt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Reference model
    logic [31:0] m_cnt, m_lim;
    logic        m_en, m_os, m_ie, m_pend;

    always #2.5 clk = ~clk;

    evtimer_chan u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_read(logic [ADDR_W-1:0] a);
        logic [31:0] st;
        st = {24'd0, m_pend, m_ie, m_os, m_en, (m_en ? 4'd2 : 4'd1)};
        case (a)
            6'h10:   return st;
            6'h14:   return m_cnt;
            6'h18:   return m_lim;
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_lim = 32'hFFFF_FFFF; m_en = 0; m_os = 0; m_ie = 0; m_pend = 0;
    endtask

    task automatic model_step(logic wr, logic [ADDR_W-1:0] a, logic [31:0] d, logic t);
        logic adv, exp_hit;
        adv     = m_en && t && !(wr && (a == 6'h00 || a == 6'h08));
        exp_hit = adv && (m_cnt >= m_lim);
        if (exp_hit && m_os) m_en = 0;
        if (exp_hit) begin m_cnt = 0; m_pend = 1; end
        else if (adv) m_cnt = m_cnt + 1;
        if (wr) begin
            case (a)
                6'h00: begin m_cnt = 0; m_pend = 0; m_en = 0; end
                6'h04: m_en = 1;
                6'h08: m_en = 0;
                6'h0C: m_os = d[0];
                6'h18: m_lim = d;
                6'h1C: m_ie = d[0];
                6'h20: if (d[7] && !exp_hit) m_pend = 0;
                default: ;
            endcase
        end
    endtask

    task automatic step(logic wr, logic [ADDR_W-1:0] a, logic [31:0] d, logic t);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; tick_en = t;
        @(posedge clk);
        model_step(wr, a, d, t);
        #1;
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        step(1'b1, a, d, 1'b0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1'b0, 6'h00, 32'd0, 1'b1);
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_check(string tag, logic [ADDR_W-1:0] a);
        @(negedge clk);
        reg_wr = 0; tick_en = 0; reg_addr = a; reg_wdata = '0;
        #1;
        check(tag, reg_rdata, exp_read(a));
    endtask

    task automatic check_all(string tag);
        rd_check({tag, " status"}, 6'h10);
        rd_check({tag, " count"}, 6'h14);
        rd_check({tag, " limit"}, 6'h18);
        check({tag, " irq R8"}, {31'd0, irq}, {31'd0, m_pend & m_ie});
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset values, literal
        rd_check("R1 status", 6'h10);
        check("R1 status literal", reg_rdata, 32'h01);
        rd_check("R1 count", 6'h14);
        rd_check("R1 limit", 6'h18);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R4 ticks while disabled
        ticks(5);
        check_all("R4 disabled");

        // R9 R3 R2 setup with random data on command writes
        wr(6'h18, 32'd3);
        wr(6'h0C, 32'hFFFF_FFFE);
        wr(6'h1C, 32'h1);
        wr(6'h04, $urandom);
        rd_check("R2 active", 6'h10);
        check("R2 literal 0x52", reg_rdata, 32'h52);
        ticks(3);
        check_all("R4 R5 pre-expiry");
        ticks(1);
        check_all("R5 expiry");
        check("R8 irq literal", {31'd0, irq}, 32'd1);

        // R7 ack without bit 7, then with
        wr(6'h20, 32'h7F);
        check_all("R7 ack no bit7");
        wr(6'h20, 32'h80);
        check_all("R7 ack cleared");

        // R8 interrupt disabled masks irq
        wr(6'h1C, 32'h0);
        ticks(4);
        check_all("R8 masked");
        // R7 expiry beats ack on the same edge (count 0..3 again)
        ticks(3);
        step(1'b1, 6'h20, 32'h80, 1'b1);
        check_all("R7 expiry wins");

        // R3 disable holds count
        ticks(2);
        wr(6'h08, $urandom);
        ticks(6);
        check_all("R3 R4 stopped");

        // R6 one-shot
        wr(6'h00, 32'h0);
        wr(6'h0C, 32'h1);
        wr(6'h04, 32'h0);
        ticks(4);
        check_all("R6 fired");
        rd_check("R6 idle literal", 6'h10);
        check("R6 status 0xA1", reg_rdata, 32'hA1);
        ticks(5);
        check_all("R6 stays stopped");

        // R10 clear command with random data
        wr(6'h04, 32'h0);
        ticks(2);
        wr(6'h00, $urandom);
        check_all("R10 clear");

        // R11 free running
        wr(6'h0C, 32'h0);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h04, 32'h0);
        ticks(150);
        check_all("R11 free run");
        check("R11 count literal", exp_read(6'h14), 32'd150);

        // R12 unmapped and write-only reads
        rd_check("R12 off 0x00", 6'h00);
        rd_check("R12 off 0x20", 6'h20);
        rd_check("R12 off 0x3C", 6'h3C);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            int sel;
            sel = $urandom_range(0, 8);
            a = 6'(sel * 4);
            d = $urandom;
            if (a == 6'h18) d = $urandom_range(0, 6);
            if (a == 6'h20 && $urandom_range(0, 1) == 1) d = 32'h80;
            if ($urandom_range(0, 2) == 0)
                step(1'b1, a, d, 1'($urandom_range(0, 1)));
            else
                ticks($urandom_range(1, 4));
            if (i % 4 == 0) check_all("R5 R7 random");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule